// File: doc/BRIEF.md
# Coarse-Fine Time Interval Counter

The block measures the time from a start event to a stop event. It combines two measurements. A coarse counter counts whole reference-clock periods between the clock edge that samples the start event and the clock edge that samples the stop event. A single external tapped delay line supplies the fine part. Its tap states arrive as a thermometer word `taps`, and the block samples that word on the same edges. Bit i is 1 when the event edge has already passed delay unit i.

Only one delay line and one capture register exist, so the two fine measurements happen in turn. The start-side snapshot is decoded, offered on `fine_cnt` with `snap_rdy`, and must be acknowledged with `snap_ack` before a stop event can be taken. The line is then reused for the stop side. The result is `n0*T0 + (n1 - n2)*TD` in a common fixed-point time unit, where n0 is the coarse count, n1 is the start-side unit count and n2 is the stop-side unit count.

The measured value then stays on `result` with `done` high until a one-cycle `clr` pulse returns the block to idle. The interval carries an inherent uncertainty of about two delay units.

Top module: `tic_core`

## Requirements
- R1: After reset, `done`, `err`, `ovf`, `snap_rdy`, `fine_cnt` and `result` are all 0.
- R2: A snapshot decodes to the number of consecutive 1 bits starting at tap bit 0. For example, 16'h00FF gives 8 and 16'h0000 gives 0.
- R3: A snapshot with a bubble decodes to the index of its first 0 bit, and later 1 bits are ignored. For example, 16'h00F7 gives 3.
- R4: A snapshot whose taps are all 1 decodes to TAPS and sets `ovf` for that measurement.
- R5: One cycle after the stop capture edge, `done` rises and `result` equals n0*T0 + (n1-n2)*TD as a signed value. Here n0 is the number of clock edges from the start capture edge to the stop capture edge.
- R6: From the start capture until `snap_ack` is sampled, `snap_rdy` is high and `fine_cnt` shows the decoded start count. After the acknowledgement, `snap_rdy` returns to 0.
- R7: A stop event sampled while `snap_rdy` is high ends the measurement with `done` and `err` both high.
- R8: The coarse count saturates at 2^CW-1 instead of wrapping, and `ovf` is set.
- R9: `done` and `result` hold until `clr` is sampled. `arm` has no effect while `done` is high. After `clr`, a new `arm` starts a fresh measurement that clears `err` and `ovf`.
- R10: A stop event is ignored while the block waits for the start event. A start event is ignored while the coarse counter runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | reference clock; one period is T0 units |
| rst_n | input | 1 | asynchronous active-low reset |
| arm | input | 1 | begin waiting for a start event (idle only) |
| start_evt | input | 1 | start event, synchronous to clk |
| stop_evt | input | 1 | stop event, synchronous to clk |
| taps | input | TAPS | thermometer snapshot of the delay line, bit 0 first |
| snap_ack | input | 1 | start snapshot has been read out |
| clr | input | 1 | one-cycle acknowledge of a finished measurement |
| snap_rdy | output | 1 | start snapshot waiting to be read |
| fine_cnt | output | $clog2(TAPS+1) | decoded start-side unit count |
| done | output | 1 | measurement finished |
| err | output | 1 | stop event arrived before the start snapshot was read |
| ovf | output | 1 | coarse saturation or a full delay line during this measurement |
| result | output | CW+$clog2(T0+1)+2 | signed interval in fixed-point units |

## Verification
The assertions assume that the start and stop events are already synchronous to `clk`. They also assume that `taps` is meaningful only in the cycle an event is sampled, and that TAPS*TD does not exceed T0, so the fine correction never outweighs one coarse period. The stimulus drives every input on the falling clock edge, holds each event for exactly one cycle, and pairs a tap word with each event. It stays within a line length equal to one period, except for the deliberate full-line and bubble patterns.

// File: rtl/tic_core.sv
module tic_core #(
  parameter int TAPS = 16,
  parameter int CW   = 12,
  parameter int T0   = 64,
  parameter int TD   = 4,
  localparam int FW  = $clog2(TAPS + 1),
  localparam int RW  = CW + $clog2(T0 + 1) + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm,
  input  logic                 start_evt,
  input  logic                 stop_evt,
  input  logic [TAPS-1:0]      taps,
  input  logic                 snap_ack,
  input  logic                 clr,
  output logic                 snap_rdy,
  output logic [FW-1:0]        fine_cnt,
  output logic                 done,
  output logic                 err,
  output logic                 ovf,
  output logic signed [RW-1:0] result
);

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_CAP_A, S_RUN, S_CAP_B, S_DONE} st_t;
  localparam logic [CW-1:0] CMAX = '1;

  st_t           st;
  logic [CW-1:0] coarse;
  logic [FW-1:0] n_a, n_b;

  function automatic logic [FW-1:0] therm_count(input logic [TAPS-1:0] t);
    logic hit;
    therm_count = '0;
    hit = 1'b0;
    for (int i = 0; i < TAPS; i++) begin
      if (!hit) begin
        if (t[i]) therm_count = therm_count + 1'b1;
        else      hit = 1'b1;
      end
    end
  endfunction

  logic [FW-1:0] dec;
  logic          full, counting;
  assign dec      = therm_count(taps);
  assign full     = &taps;
  assign counting = (st == S_CAP_A) || (st == S_RUN);

  assign snap_rdy = (st == S_CAP_A);
  assign done     = (st == S_DONE);
  assign fine_cnt = snap_rdy ? n_a : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      coarse <= '0;
      n_a    <= '0;
      n_b    <= '0;
      err    <= 1'b0;
      ovf    <= 1'b0;
      result <= '0;
    end else begin
      if (counting) begin
        if (coarse != CMAX) coarse <= coarse + 1'b1;
        else                ovf    <= 1'b1;
      end
      unique case (st)
        S_IDLE: if (arm) begin
          st  <= S_ARM;
          err <= 1'b0;
          ovf <= 1'b0;
        end
        S_ARM: if (start_evt) begin
          st     <= S_CAP_A;
          coarse <= '0;
          n_a    <= dec;
          if (full) ovf <= 1'b1;
        end
        S_CAP_A: begin
          if (stop_evt) begin
            st  <= S_DONE;
            err <= 1'b1;
          end else if (snap_ack) begin
            st <= S_RUN;
          end
        end
        S_RUN: if (stop_evt) begin
          st  <= S_CAP_B;
          n_b <= dec;
          if (full) ovf <= 1'b1;
        end
        S_CAP_B: begin
          st     <= S_DONE;
          result <= $signed(RW'(coarse) * RW'(T0) + (RW'(n_a) - RW'(n_b)) * RW'(TD));
        end
        S_DONE: if (clr) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_FINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    snap_rdy |-> fine_cnt <= FW'(TAPS)); // R2
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    snap_rdy && snap_ack && !stop_evt |=> !snap_rdy && !done); // R6
  AST_EARLY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    snap_rdy && stop_evt |=> done && err); // R7
  AST_ERR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done || st == S_IDLE); // R7
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    counting && coarse == CMAX |=> ovf && coarse == CMAX); // R8
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !clr |=> done && $stable(result) && $stable(err)); // R9
  AST_IDLE_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    done && clr |=> !done && !snap_rdy); // R9

endmodule

// File: tb/sim_tic_core.sv
`timescale 1ns/1ps
module sim_tic_core;
  localparam int TAPS = 16, CW = 12, T0 = 64, TD = 4;
  localparam int FW = $clog2(TAPS + 1);
  localparam int RW = CW + $clog2(T0 + 1) + 2;

  logic clk = 0, rst_n = 0, arm = 0, start_evt = 0, stop_evt = 0, snap_ack = 0, clr = 0;
  logic [TAPS-1:0] taps = '0;
  logic snap_rdy, done, err, ovf;
  logic [FW-1:0] fine_cnt;
  logic signed [RW-1:0] result;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tic_core #(.TAPS(TAPS), .CW(CW), .T0(T0), .TD(TD)) u0 (
    .clk, .rst_n, .arm, .start_evt, .stop_evt, .taps, .snap_ack, .clr,
    .snap_rdy, .fine_cnt, .done, .err, .ovf, .result);

  // {start taps, n1, stop taps, n2, edges}
  localparam logic [63:0] VEC [5] = '{
    {16'h00FF, 8'd8,  16'h000F, 8'd4,  16'd3},
    {16'h0001, 8'd1,  16'h3FFF, 8'd14, 16'd10},
    {16'h00F7, 8'd3,  16'h0000, 8'd0,  16'd2},
    {16'h0000, 8'd0,  16'h0FFF, 8'd12, 16'd2},
    {16'h7FFF, 8'd15, 16'hFF0B, 8'd2,  16'd7}
  };

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    finished = 1;
    $finish;
  endtask

  // arm, start at edge E0, ack at E1, stop at edge Ek; ends at negedge after done
  task automatic measure(input logic [15:0] st, input int n1, input logic [15:0] sp, input int k);
    @(negedge clk) arm = 1;
    @(negedge clk) begin arm = 0; start_evt = 1; taps = st; end
    @(negedge clk) begin start_evt = 0; taps = '0; end
    check("R6 snap_rdy", snap_rdy, 1);
    check("R2 R3 R4 fine_cnt", fine_cnt, n1);
    snap_ack = 1;
    @(negedge clk) snap_ack = 0;
    check("R6 released", snap_rdy, 0);
    repeat (k - 2) @(negedge clk);
    stop_evt = 1; taps = sp;
    @(negedge clk) begin stop_evt = 0; taps = '0; end
    check("R5 not yet done", done, 0);
    @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr = 1;
    @(negedge clk) clr = 0;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 done", done, 0);
    check("R1 err", err, 0);
    check("R1 ovf", ovf, 0);
    check("R1 snap_rdy", snap_rdy, 0);
    check("R1 fine_cnt", fine_cnt, 0);
    check("R1 result", result, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 5; i++) begin
      measure(VEC[i][63:48], int'(VEC[i][47:40]), VEC[i][39:24], int'(VEC[i][15:0]));
      check("R5 done", done, 1);
      check("R5 result", result,
            int'(VEC[i][15:0]) * T0 + (int'(VEC[i][47:40]) - int'(VEC[i][23:16])) * TD);
      check("R5 ovf clear", ovf, 0);
      pulse_clr();
      check("R9 idle after clr", done, 0);
    end

    // R4: full line at start
    measure(16'hFFFF, 16, 16'h0000, 4);
    check("R4 result", result, 4 * T0 + 16 * TD);
    check("R4 ovf", ovf, 1);
    // R9: arm while done has no effect, result holds
    arm = 1;
    repeat (3) @(negedge clk);
    arm = 0;
    check("R9 done held", done, 1);
    check("R9 result held", result, 4 * T0 + 16 * TD);
    pulse_clr();

    // R7: stop before the snapshot is read
    @(negedge clk) arm = 1;
    @(negedge clk) begin arm = 0; start_evt = 1; taps = 16'h0007; end
    @(negedge clk) begin start_evt = 0; taps = 16'h00FF; stop_evt = 1; end
    @(negedge clk) begin stop_evt = 0; taps = '0; end
    check("R7 done", done, 1);
    check("R7 err", err, 1);
    pulse_clr();

    // R10: stop in ARM ignored; start in RUN ignored
    @(negedge clk) arm = 1;
    @(negedge clk) begin arm = 0; stop_evt = 1; taps = 16'h00FF; end
    @(negedge clk) begin stop_evt = 0; taps = '0; end
    check("R10 stop while waiting", done, 0);
    check("R10 no snapshot", snap_rdy, 0);
    check("R9 err cleared by arm", err, 0);
    start_evt = 1; taps = 16'h0003;               // E0
    @(negedge clk) begin start_evt = 0; taps = '0; snap_ack = 1; end
    @(negedge clk) begin snap_ack = 0; start_evt = 1; taps = 16'h3FFF; end  // E2 ignored
    @(negedge clk) begin start_evt = 0; taps = '0; end
    @(negedge clk) begin stop_evt = 1; taps = 16'h0001; end                 // stop at E4
    @(negedge clk) begin stop_evt = 0; taps = '0; end
    @(negedge clk);
    check("R10 result", result, 4 * T0 + (2 - 1) * TD);
    pulse_clr();

    // R8: coarse saturation
    measure(16'h000F, 4, 16'h0003, 5000);
    check("R8 result", result, 4095 * T0 + (4 - 2) * TD);
    check("R8 ovf", ovf, 1);
    pulse_clr();

    // R9: fresh measurement after clr clears ovf
    measure(16'h001F, 5, 16'h0001, 2);
    check("R9 fresh result", result, 2 * T0 + 4 * TD);
    check("R9 fresh ovf", ovf, 0);
    pulse_clr();

    summary();
  end
endmodule